// File: doc/BRIEF.md
# Handshake Bus Master with Acknowledge Timeout

This block is the initiating end of an 8-bit multiplexed request/acknowledge bus. A local client hands it one request: read or write, an 8-bit address, 16 bits of write data, and a flag that selects a single byte instead of a full word. The master first runs an address phase. It then runs one or two data phases, and it returns the read bytes together with a one-cycle completion pulse and a failure flag.

Every phase follows the same four-step pattern. The master sets the shared lanes first. It then raises the request strobe, waits for the responder to acknowledge, drops the strobe, and waits for the acknowledge to return low. The byte strobes tell the responder what kind of phase it is: with both strobes low it is an address phase, and with one strobe high it is a data phase for that lane. The lane output enable turns the bus around before a read phase, so that the master never drives while the responder does. If either acknowledge edge fails to arrive within a parameterised number of cycles, the transaction is abandoned, the bus is released and the failure flag is raised.

Top module: `hsbus_master`

## Requirements
- R1: After reset, bus_req, bus_hi, bus_lo, bus_ad_oe, busy, done and fail are low, and bus_rd is high.
- R2: Each transaction begins with an address phase. The lanes carry req_addr with bus_ad_oe high, both byte strobes are low and bus_rd is high. The lanes hold that value for at least one cycle before bus_req rises.
- R3: A word transfer runs the address phase, then a bus_hi phase, then a bus_lo phase. A byte transfer runs one data phase: bus_lo for an odd address and bus_hi for an even address. bus_hi and bus_lo are never high together and are only high while bus_req is high.
- R4: In a write data phase, bus_rd is low exactly while the byte strobe is high (bus_rd: 1 = read, 0 = write). The lanes carry req_wdata[15:8] for a bus_hi phase and req_wdata[7:0] for a bus_lo phase, and that value is stable on the lanes before bus_req rises.
- R5: In a read data phase, bus_ad_oe is low for at least one cycle before bus_req rises and stays low while bus_req is high. The byte on bus_ad_i when the acknowledge is seen goes to rdata[15:8] for a bus_hi phase and to rdata[7:0] for a bus_lo phase. An unused lane of rdata reads zero.
- R6: bus_req stays high until bus_ack is sampled high and then drops. A new phase does not raise bus_req until bus_ack has been sampled low.
- R7: If bus_ack is still low on the TIMEOUT_CYC+1-th consecutive edge with bus_req high, the transaction ends with done and fail high, and bus_req, the strobes and bus_ad_oe are low.
- R8: After a phase is acknowledged, the same TIMEOUT_CYC+1 limit applies to bus_ack returning low. Missing it ends the transaction as in R7.
- R9: done is a single-cycle pulse. fail is low after a transaction completes normally. busy is high from the cycle after a start is accepted through the done cycle, and low after that.
- R10: req_start is ignored while busy is high. The running transaction is unchanged and no further transaction follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start a transaction (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = single byte, 0 = 16-bit word |
| req_addr | input | 8 | Transaction address (odd = low byte) |
| req_wdata | input | 16 | Write data, high byte in [15:8] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Transaction aborted by timeout (valid with done) |
| rdata | output | 16 | Read result, high byte in [15:8] |
| bus_ad_i | input | 8 | Lane values driven by the responder |
| bus_ad_o | output | 8 | Lane values driven by the master |
| bus_ad_oe | output | 1 | Master lane output enable |
| bus_req | output | 1 | Phase request strobe |
| bus_rd | output | 1 | Direction: 1 read, 0 write |
| bus_hi | output | 1 | High-byte data phase strobe |
| bus_lo | output | 1 | Low-byte data phase strobe |
| bus_ack | input | 1 | Responder acknowledge |

## Verification
Two events can land on the same clock edge. The first pair is the timeout expiry and a late acknowledge. In that case the acknowledge must win, and one cycle later the abort must win. The bench covers this with a responder whose acknowledge latency is exactly TIMEOUT_CYC+1 cycles, which must complete, and one cycle longer, which must fail. The release wait gets the same treatment with a held and a stuck acknowledge. The second pair is a new start request arriving during a running transaction. The bench judges it from the phase log the responder model records and from the absence of any later strobe.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE,
    ST_DONE
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_HIGH,
    PH_LOW
  } ph_e;

  // First data phase: words start high, bytes pick the lane from address bit 0
  function automatic ph_e first_data(input logic byte_mode, input logic addr_odd);
    if (byte_mode && addr_odd) return PH_LOW;
    return PH_HIGH;
  endfunction

  function automatic ph_e next_phase(input ph_e ph, input logic byte_mode, input logic addr_odd);
    if (ph == PH_ADDR) return first_data(byte_mode, addr_odd);
    return PH_LOW;
  endfunction

  function automatic logic last_phase(input ph_e ph, input logic byte_mode);
    return (ph != PH_ADDR) && (byte_mode || ph == PH_LOW);
  endfunction

endpackage

// File: rtl/hsbus_timer.sv
module hsbus_timer #(
  parameter int LIMIT = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= CW'(LIMIT);
    else if (reload)                cnt_q <= CW'(LIMIT);
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = run && (cnt_q == '0);
endmodule

// File: rtl/hsbus_drive.sv
module hsbus_drive import hsbus_pkg::*; #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  st_e                   nst,
  input  ph_e                   nph,
  input  logic                  nwr,
  input  logic [LANE_W-1:0]     naddr,
  input  logic [2*LANE_W-1:0]   nwdata,
  output logic [LANE_W-1:0]     bus_ad_o,
  output logic                  bus_ad_oe,
  output logic                  bus_req,
  output logic                  bus_rd,
  output logic                  bus_hi,
  output logic                  bus_lo
);
  logic              active, strobe, own_lanes;
  logic [LANE_W-1:0] lane_val;

  assign active    = (nst == ST_SETUP) || (nst == ST_STROBE) || (nst == ST_RELEASE);
  assign strobe    = (nst == ST_STROBE);
  assign own_lanes = active && ((nph == PH_ADDR) || nwr);

  always_comb begin
    unique case (nph)
      PH_HIGH: lane_val = nwdata[2*LANE_W-1:LANE_W];
      PH_LOW:  lane_val = nwdata[LANE_W-1:0];
      default: lane_val = naddr;
    endcase
  end

  // Outputs registered from next state so every pin changes cleanly on an edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ad_o  <= '0;
      bus_ad_oe <= 1'b0;
      bus_req   <= 1'b0;
      bus_rd    <= 1'b1;
      bus_hi    <= 1'b0;
      bus_lo    <= 1'b0;
    end else begin
      bus_ad_o  <= own_lanes ? lane_val : '0;
      bus_ad_oe <= own_lanes;
      bus_req   <= strobe;
      bus_rd    <= !(strobe && nwr && nph != PH_ADDR);
      bus_hi    <= strobe && (nph == PH_HIGH);
      bus_lo    <= strobe && (nph == PH_LOW);
    end
  end
endmodule

// File: rtl/hsbus_master.sv
module hsbus_master import hsbus_pkg::*; #(
  parameter int TIMEOUT_CYC = 255,
  parameter int LANE_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_start,
  input  logic                  req_write,
  input  logic                  req_byte,
  input  logic [LANE_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic                  fail,
  output logic [2*LANE_W-1:0]   rdata,
  input  logic [LANE_W-1:0]     bus_ad_i,
  output logic [LANE_W-1:0]     bus_ad_o,
  output logic                  bus_ad_oe,
  output logic                  bus_req,
  output logic                  bus_rd,
  output logic                  bus_hi,
  output logic                  bus_lo,
  input  logic                  bus_ack
);
  localparam int DW = 2 * LANE_W;

  st_e st_q, st_n;
  ph_e ph_q, ph_n;

  logic              wr_q, byte_q;
  logic [LANE_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [DW-1:0]     rdata_q;
  logic              fail_q, done_q;

  // Named internal events (observed by the checker)
  logic accept, reload, wait_rise, wait_fall, tmo_fire, capture;

  logic              wr_n, byte_n;
  logic [LANE_W-1:0] addr_n;
  logic [DW-1:0]     wdata_n;

  assign wait_rise = (st_q == ST_STROBE)  && !bus_ack;
  assign wait_fall = (st_q == ST_RELEASE) &&  bus_ack;
  assign capture   = (st_q == ST_STROBE) && bus_ack && !wr_q && (ph_q != PH_ADDR);

  hsbus_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (reload),
    .run     (wait_rise || wait_fall),
    .expired (tmo_fire)
  );

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    accept = 1'b0;
    reload = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_start) begin
        accept = 1'b1;
        st_n   = ST_SETUP;
        ph_n   = PH_ADDR;
      end
      ST_SETUP: begin
        st_n   = ST_STROBE;
        reload = 1'b1;
      end
      ST_STROBE: begin
        if (bus_ack) begin
          st_n   = ST_RELEASE;
          reload = 1'b1;
        end else if (tmo_fire) begin
          st_n   = ST_DONE;
        end
      end
      ST_RELEASE: begin
        if (!bus_ack) begin
          if (last_phase(ph_q, byte_q)) st_n = ST_DONE;
          else begin
            st_n = ST_SETUP;
            ph_n = next_phase(ph_q, byte_q, addr_q[0]);
          end
        end else if (tmo_fire) begin
          st_n = ST_DONE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Request fields as seen by the pin stage in the cycle they take effect
  assign wr_n    = accept ? req_write : wr_q;
  assign byte_n  = accept ? req_byte  : byte_q;
  assign addr_n  = accept ? req_addr  : addr_q;
  assign wdata_n = accept ? req_wdata : wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ADDR;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      fail_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      ph_q    <= ph_n;
      wr_q    <= wr_n;
      byte_q  <= byte_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      done_q  <= (st_n == ST_DONE);
      if (accept) begin
        rdata_q <= '0;
        fail_q  <= 1'b0;
      end else begin
        if (capture && ph_q == PH_HIGH) rdata_q[DW-1:LANE_W] <= bus_ad_i;
        if (capture && ph_q == PH_LOW)  rdata_q[LANE_W-1:0]  <= bus_ad_i;
        if (tmo_fire) fail_q <= 1'b1;
      end
    end
  end

  hsbus_drive #(.LANE_W(LANE_W)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .nst       (st_n),
    .nph       (ph_n),
    .nwr       (wr_n),
    .naddr     (addr_n),
    .nwdata    (wdata_n),
    .bus_ad_o  (bus_ad_o),
    .bus_ad_oe (bus_ad_oe),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_hi    (bus_hi),
    .bus_lo    (bus_lo)
  );

  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign fail  = fail_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/hsbus_master_chk.sv
module hsbus_master_chk #(
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [LANE_W-1:0] bus_ad_o,
  input logic              bus_ad_oe,
  input logic              bus_req,
  input logic              bus_rd,
  input logic              bus_hi,
  input logic              bus_lo,
  input logic              bus_ack,
  input logic              tmo
);
  // R2, R4: driven lanes settle a cycle before the strobe rises
  a_r2_lanes_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && bus_ad_oe |-> $past(bus_ad_oe) && $stable(bus_ad_o));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_hi && bus_lo));

  a_r3_strobe_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hi || bus_lo) |-> bus_req);

  a_r4_write_with_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_req && (bus_hi || bus_lo));

  a_r5_released_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_rd && (bus_hi || bus_lo) |-> !bus_ad_oe);

  a_r5_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) && !bus_ad_oe |-> !$past(bus_ad_oe));

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !tmo |=> bus_req);

  a_r6_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> done && fail && !bus_req && !bus_ad_oe && !bus_hi && !bus_lo);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind hsbus_master hsbus_master_chk #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .bus_ad_o  (bus_ad_o),
  .bus_ad_oe (bus_ad_oe),
  .bus_req   (bus_req),
  .bus_rd    (bus_rd),
  .bus_hi    (bus_hi),
  .bus_lo    (bus_lo),
  .bus_ack   (bus_ack),
  .tmo       (tmo_fire)
);

// File: tb/hsbus_master_test.sv
module hsbus_master_test;
  localparam int LIMIT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, fail;
  logic [15:0] rdata;
  logic [7:0]  bus_ad_i, bus_ad_o;
  logic        bus_ad_oe, bus_req, bus_rd, bus_hi, bus_lo;
  logic        bus_ack = 1'b0;

  always #2 clk = ~clk;

  hsbus_master #(.TIMEOUT_CYC(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .fail(fail), .rdata(rdata),
    .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_hi(bus_hi), .bus_lo(bus_lo),
    .bus_ack(bus_ack)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- responder model ----------------
  logic [7:0] mem [0:255];
  logic [7:0] s_addr = '0;
  int  s_dly = 1, s_rel = 1;
  bit  s_stuck = 1'b0;
  int  ph_n = 0, hs_viol = 0, req_rises = 0;
  logic [1:0] ph_code [0:3];
  logic       ph_rd   [0:3];
  logic       ph_oe   [0:3];
  logic [7:0] ph_ado  [0:3];

  assign bus_ad_i = (bus_req && bus_rd && (bus_hi || bus_lo)) ? mem[{s_addr[7:1], bus_lo}] : 8'hEE;

  initial begin
    int acnt = 0, rcnt = 0;
    bit req_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        rcnt = 0;
        if (!req_prev) begin
          req_rises++;
          if (bus_ack) hs_viol++;
        end
        if (!bus_ack) begin
          acnt++;
          if (acnt >= s_dly) begin
            bus_ack = 1'b1;
            if (ph_n < 4) begin
              ph_code[ph_n] = {bus_hi, bus_lo};
              ph_rd[ph_n]   = bus_rd;
              ph_oe[ph_n]   = bus_ad_oe;
              ph_ado[ph_n]  = bus_ad_o;
            end
            ph_n++;
            if (!bus_hi && !bus_lo) s_addr = bus_ad_o;
            else if (!bus_rd) mem[{s_addr[7:1], bus_lo}] = bus_ad_o;
          end
        end
      end else begin
        acnt = 0;
        if (bus_ack && !s_stuck) begin
          rcnt++;
          if (rcnt >= s_rel) begin
            bus_ack = 1'b0;
            rcnt = 0;
          end
        end
      end
      req_prev = bus_req;
    end
  end

  // ---------------- transaction driver ----------------
  bit          t_fail, t_busy_ok, t_hung;
  logic [15:0] t_rd;

  task automatic run_txn(input bit wr, input bit bm, input logic [7:0] a, input logic [15:0] wd, input bit poke);
    int n;
    ph_n = 0; hs_viol = 0; t_hung = 1'b0;
    @(negedge clk);
    req_start = 1'b1; req_write = wr; req_byte = bm; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_start = 1'b0;
    t_busy_ok = busy;
    n = 0;
    while (!done && n < 2000) begin
      if (poke && n == 2) begin
        req_start = 1'b1; req_write = !wr; req_byte = !bm; req_addr = a ^ 8'h55; req_wdata = ~wd;
      end else req_start = 1'b0;
      @(negedge clk);
      n++;
    end
    req_start = 1'b0;
    if (n >= 2000) begin
      t_hung = 1'b1;
      chk(1'b0, "watchdog: done never rose", 0, 1);
    end
    t_fail = fail; t_rd = rdata;
    t_busy_ok = t_busy_ok && busy;
    @(negedge clk);
    t_busy_ok = t_busy_ok && !busy && !done;
  endtask

  // Checks the phase log against R2..R5 for a completed transaction
  task automatic check_phases(input bit wr, input bit bm, input logic [7:0] a, input logic [15:0] wd);
    logic [1:0] exp_code [0:2];
    int exp_n;
    bit ok;
    exp_code[0] = 2'b00;
    if (!bm) begin exp_n = 3; exp_code[1] = 2'b10; exp_code[2] = 2'b01; end
    else begin exp_n = 2; exp_code[1] = a[0] ? 2'b01 : 2'b10; exp_code[2] = 2'b00; end
    chk(ph_n == exp_n, "R3 phase count", ph_n, exp_n);
    ok = (ph_n == exp_n);
    for (int i = 0; i < exp_n && i < ph_n; i++) ok = ok && (ph_code[i] == exp_code[i]);
    chk(ok, "R3 phase strobe order", {ph_code[0], ph_code[1], ph_code[2]},
        {exp_code[0], exp_code[1], exp_code[2]});
    chk(ph_oe[0] && ph_ado[0] == a && ph_rd[0], "R2 address phase lanes", {ph_oe[0], ph_rd[0], ph_ado[0]}, {2'b11, a});
    for (int i = 1; i < exp_n && i < ph_n; i++) begin
      if (wr) begin
        logic [7:0] eb;
        eb = ph_code[i][1] ? wd[15:8] : wd[7:0];
        chk(!ph_rd[i] && ph_oe[i] && ph_ado[i] == eb, "R4 write data phase",
            {ph_rd[i], ph_oe[i], ph_ado[i]}, {2'b01, eb});
      end else begin
        chk(ph_rd[i] && !ph_oe[i], "R5 read phase released lanes", {ph_rd[i], ph_oe[i]}, 2'b10);
      end
    end
    chk(hs_viol == 0, "R6 strobe before ack low", hs_viol, 0);
  endtask

  typedef struct packed {
    logic        wr;
    logic        bm;
    logic [7:0]  a;
    logic [15:0] wd;
    logic [7:0]  dly;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 1'b0, 8'h20, 16'hA1B2, 8'd1},
    '{1'b0, 1'b0, 8'h20, 16'h0000, 8'd3},
    '{1'b1, 1'b1, 8'h21, 16'h00C3, 8'd2},
    '{1'b0, 1'b0, 8'h20, 16'h0000, 8'd1},
    '{1'b1, 1'b1, 8'h44, 16'h5D00, 8'd4},
    '{1'b0, 1'b1, 8'h44, 16'h0000, 8'd1},
    '{1'b0, 1'b1, 8'h45, 16'h0000, 8'd7},
    '{1'b0, 1'b0, 8'h91, 16'h0000, 8'd2}
  };

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_req && !bus_hi && !bus_lo && !bus_ad_oe && bus_rd && !busy && !done && !fail,
        "R1 reset outputs", {bus_req, bus_hi, bus_lo, bus_ad_oe, bus_rd, busy, done, fail}, 8'b00001000);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      vec_t t;
      logic [7:0]  ev, od;
      logic [15:0] exp_rd;
      t  = VECS[v];
      ev = {t.a[7:1], 1'b0};
      od = {t.a[7:1], 1'b1};
      if (!t.bm)     exp_rd = {mem[ev], mem[od]};
      else if (t.a[0]) exp_rd = {8'h00, mem[od]};
      else           exp_rd = {mem[ev], 8'h00};
      s_dly = int'(t.dly);
      run_txn(t.wr, t.bm, t.a, t.wd, 1'b0);
      chk(!t_fail, "R9 fail low on success", t_fail, 0);
      chk(t_busy_ok, "R9 busy/done window", t_busy_ok, 1);
      check_phases(t.wr, t.bm, t.a, t.wd);
      if (t.wr) begin
        if (!t.bm) chk({mem[ev], mem[od]} == t.wd, "R4 word written", {mem[ev], mem[od]}, t.wd);
        else if (t.a[0]) chk(mem[od] == t.wd[7:0], "R4 low byte written", mem[od], t.wd[7:0]);
        else chk(mem[ev] == t.wd[15:8], "R4 high byte written", mem[ev], t.wd[15:8]);
      end else begin
        chk(t_rd == exp_rd, "R5 read data lanes", t_rd, exp_rd);
      end
    end
    s_dly = 1;

    // R7 boundary: acknowledge one cycle too late aborts in the address phase
    s_dly = LIMIT + 2;
    run_txn(1'b0, 1'b0, 8'h30, 16'h0, 1'b0);
    chk(t_fail, "R7 late ack aborts", t_fail, 1);
    chk(ph_n == 0, "R7 no phase acknowledged", ph_n, 0);
    chk(!bus_req && !bus_ad_oe && !bus_hi && !bus_lo, "R7 bus released after abort",
        {bus_req, bus_ad_oe, bus_hi, bus_lo}, 0);
    chk(t_busy_ok, "R9 busy/done window on abort", t_busy_ok, 1);

    // R7 recovery: the next transaction after an abort clears fail
    s_dly = LIMIT + 1;
    run_txn(1'b0, 1'b1, 8'h31, 16'h0, 1'b0);
    chk(!t_fail, "R7 ack at limit completes", t_fail, 0);
    chk(t_rd == {8'h00, mem[8'h31]}, "R5 read after abort", t_rd, {8'h00, mem[8'h31]});
    s_dly = 1;

    // R8 boundary: slow release at the limit still completes
    s_rel = LIMIT + 1;
    run_txn(1'b1, 1'b0, 8'h52, 16'h1357, 1'b0);
    chk(!t_fail, "R8 slow release completes", t_fail, 0);
    chk({mem[8'h52], mem[8'h53]} == 16'h1357, "R8 word written", {mem[8'h52], mem[8'h53]}, 16'h1357);
    s_rel = 1;

    // R8: acknowledge never falls
    s_stuck = 1'b1;
    run_txn(1'b0, 1'b0, 8'h60, 16'h0, 1'b0);
    chk(t_fail, "R8 stuck ack aborts", t_fail, 1);
    chk(ph_n == 1, "R8 abort after address phase", ph_n, 1);
    chk(!bus_req && !bus_ad_oe, "R8 bus released", {bus_req, bus_ad_oe}, 0);
    s_stuck = 1'b0;
    repeat (3) @(negedge clk);

    // R10: start pulse during a running word read is ignored
    begin
      int rises;
      logic [15:0] exp_rd;
      logic [7:0]  other_ev, other_od;
      other_ev = 8'h70 ^ 8'h55;
      other_od = other_ev;
      exp_rd = {mem[8'h70], mem[8'h71]};
      other_ev = mem[8'h25];
      other_od = mem[8'h24];
      run_txn(1'b0, 1'b0, 8'h70, 16'h0, 1'b1);
      check_phases(1'b0, 1'b0, 8'h70, 16'h0);
      chk(t_rd == exp_rd && !t_fail, "R10 running read unchanged", t_rd, exp_rd);
      chk(mem[8'h25] == other_ev && mem[8'h24] == other_od, "R10 ignored write left no trace",
          {mem[8'h24], mem[8'h25]}, {other_od, other_ev});
      rises = req_rises;
      repeat (12) @(negedge clk);
      chk(req_rises == rises && !busy, "R10 no transaction follows", req_rises, rises);
    end

    // R1 reset during activity returns the pins to idle
    @(negedge clk);
    req_start = 1'b1; req_write = 1'b1; req_byte = 1'b0; req_addr = 8'h10; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!bus_req && !bus_ad_oe && bus_rd && !busy && !done && !fail, "R1 reset mid-transaction",
        {bus_req, bus_ad_oe, bus_rd, busy, done, fail}, 6'b001000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule